// File: doc/BRIEF.md
# Command Completion Counter with Interrupt

This block keeps one channel's completion bookkeeping. Each single-cycle event pulse from the descriptor sequencer advances a hardware-owned done count modulo 64 and sets an interrupt-active flag. Software owns a second 6-bit field, the processed count. It reads the status word, handles the events it finds, then writes back the done value it has consumed. The distance between the two counts, taken modulo 64, tells software how many events arrived since its last acknowledgement, including across a wrap. Because the done field cannot be written, an event that lands between software's read and its write-back is never lost.

The interrupt line is raised while both interrupt enables in the general configuration word are set and either the two counts differ or the interrupt-active flag is set. A four-state machine (IRQ_IDLE, IRQ_LEVEL, IRQ_PULSE, IRQ_HELD) turns that pending condition into the line. It either holds the line for as long as the condition lasts (level mode) or gives one single-cycle pulse each time the condition becomes true (edge mode). Its transitions are:
- IRQ_IDLE→IRQ_LEVEL on a condition in level mode.
- IRQ_IDLE→IRQ_PULSE on a condition in edge mode.
- IRQ_PULSE→IRQ_HELD while the condition stays in edge mode.
- IRQ_LEVEL→IRQ_HELD when the mode switches to edge with the condition still true.
- IRQ_PULSE or IRQ_HELD→IRQ_LEVEL when level mode is selected with the condition true.
- Any state→IRQ_IDLE when the condition is gone.

Top module: `cmpl_irq_counter`

## Requirements
- R1: After reset the done count, the processed count and the interrupt-active flag are all zero, so the status word reads 0, and the interrupt line is low.
- R2: Each event pulse raises the done count (status bits [5:0]) by one, modulo 64, in the status word visible after the clock edge that samples the pulse.
- R3: A register write never changes the done field, whatever value is written to bits [5:0]. An event in the same cycle as a write is still counted.
- R4: A register write loads the processed count (status bits [21:16]) from write-data bits [21:16].
- R5: Every event sets the interrupt-active flag (status bit 8). A write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves it unchanged.
- R6: When an event and a flag-clearing write fall in the same cycle, the flag ends up set.
- R7: The pending condition requires both configuration bits 29 and 31 to be set, together with either a difference between the done and processed counts or a set flag. With either enable clear, the line stays low.
- R8: With configuration bit 28 set (level mode), the line rises one clock after the pending condition appears in the status word, stays high while the condition holds, and falls one clock after it ends.
- R9: With configuration bit 28 clear (edge mode), the line gives exactly one single-cycle pulse, one clock after the condition appears. There is no further pulse until the condition has cleared and appears again.
- R10: (done − processed) mod 64 equals the number of events since the processed count was last written, for up to 63 events, across a wrap of the done count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Single-cycle completion event from the sequencer |
| wr_en_i | input | 1 | Write strobe for the counter word |
| wr_data_i | input | 32 | Write data: [21:16] processed count, [8] flag keep (0 clears) |
| cfg_i | input | 32 | General configuration: [31] and [29] enables, [28] level mode |
| stat_o | output | 32 | Counter word: [21:16] processed, [8] interrupt active, [5:0] done |
| irq_o | output | 1 | Interrupt line |

## Verification
The two functions that can fall in the same cycle are the event counter and software's acknowledging write. The bench drives an event pulse and a write whose bit 8 is zero on the same clock, and in a separate case a write whose done bits carry a value different from the live count. It then judges the status word: the done field must have advanced, the processed field must hold the written value, and the flag must still be set, which keeps the level-mode line high even though the counts now match.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
    localparam int WORD_W       = 32;
    localparam int CNT_W        = 6;
    localparam int DONE_LSB     = 0;
    localparam int FLAG_BIT     = 8;
    localparam int PROC_LSB     = 16;
    localparam int LEVEL_BIT    = 28;
    localparam int IEN_BIT      = 29;
    localparam int LIST_IEN_BIT = 31;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_LEVEL = 2'd1,
        IRQ_PULSE = 2'd2,
        IRQ_HELD  = 2'd3
    } irq_state_e;
endpackage

// File: rtl/cmpl_done_ctr.sv
module cmpl_done_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    output logic [CNT_W-1:0] done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Hardware-owned count: no write path exists, so software cannot lose it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= '0;
        end else if (evt_i) begin
            done_o <= done_o + ONE;
        end
    end
endmodule

// File: rtl/cmpl_ack_reg.sv
module cmpl_ack_reg #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] proc_wr_i,
    input  logic             flag_wr_i,
    output logic [CNT_W-1:0] proc_o,
    output logic             flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proc_o <= '0;
        end else if (wr_en_i) begin
            proc_o <= proc_wr_i;
        end
    end

    // An event outranks a clearing write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (evt_i) begin
            flag_o <= 1'b1;
        end else if (wr_en_i && !flag_wr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cmpl_irq_fsm.sv
module cmpl_irq_fsm
    import cmpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic level_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (pending_i) begin
                    state_d = level_i ? IRQ_LEVEL : IRQ_PULSE;
                end
            end
            IRQ_LEVEL: begin
                if (!pending_i) begin
                    state_d = IRQ_IDLE;
                end else if (!level_i) begin
                    state_d = IRQ_HELD;
                end
            end
            IRQ_PULSE: begin
                if (!pending_i) begin
                    state_d = IRQ_IDLE;
                end else begin
                    state_d = level_i ? IRQ_LEVEL : IRQ_HELD;
                end
            end
            IRQ_HELD: begin
                if (!pending_i) begin
                    state_d = IRQ_IDLE;
                end else if (level_i) begin
                    state_d = IRQ_LEVEL;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_LEVEL) || (state_q == IRQ_PULSE);
    end
endmodule

// File: rtl/cmpl_irq_counter.sv
module cmpl_irq_counter
    import cmpl_pkg::*;
#(
    parameter int W_WORD   = WORD_W,
    parameter int W_CNT    = CNT_W,
    parameter int P_DONE   = DONE_LSB,
    parameter int P_FLAG   = FLAG_BIT,
    parameter int P_PROC   = PROC_LSB,
    parameter int P_LEVEL  = LEVEL_BIT,
    parameter int P_IEN    = IEN_BIT,
    parameter int P_LIEN   = LIST_IEN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              wr_en_i,
    input  logic [W_WORD-1:0] wr_data_i,
    input  logic [W_WORD-1:0] cfg_i,
    output logic [W_WORD-1:0] stat_o,
    output logic              irq_o
);
    logic [W_CNT-1:0] done_cnt;
    logic [W_CNT-1:0] proc_cnt;
    logic             act_flag;
    logic             enabled;
    logic             pending;
    logic             unused_bits;

    cmpl_done_ctr #(.CNT_W(W_CNT)) u_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .done_o (done_cnt)
    );

    cmpl_ack_reg #(.CNT_W(W_CNT)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .proc_wr_i (wr_data_i[P_PROC +: W_CNT]),
        .flag_wr_i (wr_data_i[P_FLAG]),
        .proc_o    (proc_cnt),
        .flag_o    (act_flag)
    );

    assign enabled = cfg_i[P_IEN] && cfg_i[P_LIEN];
    assign pending = enabled && ((done_cnt != proc_cnt) || act_flag);

    cmpl_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .level_i   (cfg_i[P_LEVEL]),
        .irq_o     (irq_o)
    );

    always_comb begin
        stat_o                     = '0;
        stat_o[P_DONE +: W_CNT]    = done_cnt;
        stat_o[P_PROC +: W_CNT]    = proc_cnt;
        stat_o[P_FLAG]             = act_flag;
    end

    // Bits of the words that carry no meaning for this block.
    assign unused_bits = ^{wr_data_i, cfg_i};
endmodule

// File: rtl/cmpl_irq_counter_chk.sv
module cmpl_irq_counter_chk
    import cmpl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_i,
    input logic              wr_en_i,
    input logic [WORD_W-1:0] wr_data_i,
    input logic [WORD_W-1:0] cfg_i,
    input logic [WORD_W-1:0] stat_o,
    input logic              irq_o
);
    logic [CNT_W-1:0] done_f;
    logic [CNT_W-1:0] proc_f;
    logic             flag_f;
    logic             en_f;
    logic             pend_f;

    assign done_f = stat_o[DONE_LSB +: CNT_W];
    assign proc_f = stat_o[PROC_LSB +: CNT_W];
    assign flag_f = stat_o[FLAG_BIT];
    assign en_f   = cfg_i[IEN_BIT] && cfg_i[LIST_IEN_BIT];
    assign pend_f = (done_f != proc_f) || flag_f;

    p_done_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> done_f == $past(done_f) + CNT_W'(1));

    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(done_f));

    p_proc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> proc_f == $past(wr_data_i[PROC_LSB +: CNT_W]));

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_f);

    p_flag_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && wr_en_i && !wr_data_i[FLAG_BIT]) |=> flag_f);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_f |=> !irq_o);

    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_f && cfg_i[LEVEL_BIT] && pend_f) |=> irq_o);

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !cfg_i[LEVEL_BIT]) |=> !irq_o);
endmodule

bind cmpl_irq_counter cmpl_irq_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_i     (cfg_i),
    .stat_o    (stat_o),
    .irq_o     (irq_o)
);

// File: tb/cmpl_irq_counter_tb.sv
module cmpl_irq_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CFG_LEVEL = 32'hB000_0000;
    localparam logic [31:0] CFG_EDGE  = 32'hA000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] cfg_i = '0;
    logic [31:0] stat_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [5:0] exp_done = '0;
    logic [5:0] exp_proc = '0;
    logic       exp_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpl_irq_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_i     (cfg_i),
        .stat_o    (stat_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        return {10'd0, exp_proc, 7'd0, exp_flag, 2'd0, exp_done};
    endfunction

    // Write word: processed value, flag keep bit, junk in the done bits.
    function automatic logic [31:0] ack(input logic [5:0] p, input logic keep);
        logic [31:0] w;
        w = '0;
        w[21:16] = p;
        w[8] = keep;
        w[5:0] = ~exp_done;
        return w;
    endfunction

    // Drive after a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cyc(input logic ev, input logic wr, input logic [31:0] d);
        evt_i = ev;
        wr_en_i = wr;
        wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        evt_i = 1'b0;
        wr_en_i = 1'b0;
        wr_data_i = '0;
        if (wr) exp_proc = d[21:16];
        if (ev) exp_flag = 1'b1;
        else if (wr && !d[8]) exp_flag = 1'b0;
        if (ev) exp_done = exp_done + 6'd1;
    endtask

    task automatic clear_all();
        cyc(1'b0, 1'b1, ack(exp_done, 1'b0));
        cyc(1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", stat_o, 32'd0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);

        // Event sweep with the line disabled: 70 events cross one wrap.
        for (int i = 1; i <= 70; i++) begin
            cyc(1'b1, 1'b0, '0);
            chk("R2 done step", {26'd0, stat_o[5:0]}, 32'(i % 64));
            chk("R7 irq off when disabled", {31'd0, irq_o}, 32'd0);
        end
        chk("R10 distance after 70 events", 32'((stat_o[5:0] - stat_o[21:16]) & 6'h3F), 32'(70 % 64));

        // Processed-count sweep with junk on the done bits.
        for (int v = 0; v < 64; v++) begin
            cyc(1'b0, 1'b1, ack(6'(v), 1'b0));
            chk("R4 processed load", {26'd0, stat_o[21:16]}, 32'(v));
            chk("R3 done untouched by write", {26'd0, stat_o[5:0]}, 32'(70 % 64));
            chk("R5 flag cleared by write", {31'd0, stat_o[8]}, 32'd0);
        end

        // Level mode.
        cfg_i = CFG_LEVEL;
        clear_all();
        chk("R7 no condition line low", {31'd0, irq_o}, 32'd0);
        cyc(1'b1, 1'b0, '0);
        chk("R8 line one clock behind status", {31'd0, irq_o}, 32'd0);
        chk("R5 flag set by event", stat_o, exp_stat());
        cyc(1'b0, 1'b0, '0);
        chk("R8 line rises", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b0, '0);
        chk("R8 line held", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b1, ack(exp_done, 1'b1));
        chk("R5 keep bit leaves flag", stat_o, exp_stat());
        chk("R5 flag still set", {31'd0, stat_o[8]}, 32'd1);
        cyc(1'b0, 1'b0, '0);
        chk("R7 flag alone holds line", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b1, ack(exp_done, 1'b0));
        chk("R8 line still high at clear", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b0, '0);
        chk("R8 line falls", {31'd0, irq_o}, 32'd0);
        cyc(1'b0, 1'b1, ack(exp_done - 6'd3, 1'b0));
        cyc(1'b0, 1'b0, '0);
        chk("R7 difference alone raises line", {31'd0, irq_o}, 32'd1);
        chk("R7 flag clear during difference", {31'd0, stat_o[8]}, 32'd0);
        // Event and clearing write in one cycle; write matches post-event done.
        cyc(1'b1, 1'b1, ack(exp_done + 6'd1, 1'b0));
        chk("R6 flag survives coincident clear", {31'd0, stat_o[8]}, 32'd1);
        chk("R3 coincident event counted", stat_o, exp_stat());
        cyc(1'b0, 1'b0, '0);
        chk("R6 line held by flag", {31'd0, irq_o}, 32'd1);
        clear_all();
        chk("R8 line low after full ack", {31'd0, irq_o}, 32'd0);

        // Edge mode.
        cfg_i = CFG_EDGE;
        cyc(1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, '0);
        chk("R9 no pulse yet", {31'd0, irq_o}, 32'd0);
        cyc(1'b0, 1'b0, '0);
        chk("R9 pulse", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b0, '0);
        chk("R9 pulse one cycle", {31'd0, irq_o}, 32'd0);
        cyc(1'b1, 1'b0, '0);
        chk("R9 no pulse on extra event", {31'd0, irq_o}, 32'd0);
        cyc(1'b0, 1'b0, '0);
        chk("R9 still no pulse", {31'd0, irq_o}, 32'd0);
        cyc(1'b0, 1'b0, '0);
        chk("R9 quiet while pending", {31'd0, irq_o}, 32'd0);
        clear_all();
        chk("R9 quiet after ack", {31'd0, irq_o}, 32'd0);
        cyc(1'b1, 1'b0, '0);
        cyc(1'b0, 1'b0, '0);
        chk("R9 rearmed pulse", {31'd0, irq_o}, 32'd1);
        cyc(1'b0, 1'b0, '0);
        chk("R9 rearmed pulse ends", {31'd0, irq_o}, 32'd0);
        clear_all();

        // Partial enables.
        cfg_i = 32'h3000_0000;
        cyc(1'b1, 1'b0, '0);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0, '0);
            chk("R7 bit 31 clear blocks line", {31'd0, irq_o}, 32'd0);
        end
        cfg_i = 32'h9000_0000;
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0, '0);
            chk("R7 bit 29 clear blocks line", {31'd0, irq_o}, 32'd0);
        end
        cfg_i = '0;
        clear_all();

        // Modular distance across a wrap.
        cyc(1'b0, 1'b1, ack(exp_done, 1'b1));
        for (int k = 1; k <= 63; k++) begin
            cyc(1'b1, 1'b0, '0);
            chk("R10 modular distance", 32'((stat_o[5:0] - stat_o[21:16]) & 6'h3F), 32'(k));
        end
        chk("R2 status model after wrap", stat_o, exp_stat());

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule